// File: doc/BRIEF.md
# Fine-Grained Engine Selection Controller

This controller sits beside a core that holds two execution engines sharing one front end and one set of caches: a wide out-of-order engine and a narrow in-order engine. Only one engine runs at a time. The controller watches strobes from whichever engine is running: retired instructions, second-level cache misses and hits, branch mispredictions, an instruction-parallelism event, a memory-parallelism event and active cycles. It counts them over a quantum of retired instructions and, at the end of each quantum, picks the engine for the next one.

At a quantum end the controller uses a linear model to predict how many cycles the idle engine would have needed for the same quantum. The model is a constant plus a weighted sum of the six event counts, with one set of loadable weights for each direction. It then forms the extra cycles the narrow engine costs over the wide one and compares them with an adaptive threshold. The threshold follows a feedback loop. Each quantum grants a budget of allowed slowdown, which is a programmable fraction of the wide engine's cycles. Cycles the narrow engine loses are charged against that budget. The accumulated balance, shifted down, becomes the new threshold. When the selection changes, the block raises a one-cycle request to the migration logic.

Top module: `core_switch_ctrl`

## Requirements
- R1: While `rst_n` is low and on release, `use_little` is 0 (wide engine), `switch_req` is 0, and the threshold, the error balance, all counters and all fourteen weights are 0.
- R2: A quantum ends in a cycle where the registered retired count is at least `quantum_len`, with a length of 0 treated as 1. In that cycle the strobes are not counted, and at the next edge the retired count and all six event counters clear to 0.
- R3: Each event counter and the retired counter adds one per cycle its strobe is high and holds at its all-ones value instead of wrapping.
- R4: The estimate is weight 0 plus the sum of weight k times counter k, with k=1 L2 miss, 2 L2 hit, 3 mispredict, 4 ILP event, 5 MLP event, 6 cycles. While the wide engine runs, weight set 0 is used and predicts narrow-engine cycles. While the narrow engine runs, set 1 is used and predicts wide-engine cycles.
- R5: Each product (signed weight times unsigned count) saturates to the signed ACC_W range, and the running sum saturates after each of the six additions, in order k=1..6.
- R6: The penalty is estimate minus measured cycles while the wide engine runs, and measured cycles minus estimate while the narrow engine runs, both saturated. The narrow engine is selected when the penalty is signed-less-than the current threshold, and the wide engine otherwise. `use_little` takes the new value at the edge that ends the quantum.
- R7: `switch_req` is high for exactly one cycle, in the cycle after a quantum end that changes `use_little`, and is low otherwise.
- R8: At each quantum end the error balance becomes sat(balance + budget − loss). The budget is sat((max(wide cycles,0) × `loss_budget`) >> 8), where the wide cycles are measured if the wide engine ran and estimated otherwise. The loss is the penalty if the narrow engine ran and 0 otherwise. The threshold becomes the new balance arithmetically shifted right by GAIN_SH (2).
- R9: When `coef_wr` is high, weight `coef_sel` of set `coef_set` takes `coef_data` at the clock edge. A `coef_sel` of 7 writes nothing. A quantum ending in the same cycle uses the old weights.
- R10: `use_little` and the threshold change only at a quantum end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| ev_l2_miss | input | 1 | Second-level cache miss strobe |
| ev_l2_hit | input | 1 | Second-level cache hit strobe |
| ev_br_mispredict | input | 1 | Branch misprediction strobe |
| ev_ilp | input | 1 | Instruction-parallelism event strobe |
| ev_mlp | input | 1 | Memory-parallelism event strobe |
| cycle_tick | input | 1 | Active engine cycle strobe |
| quantum_len | input | QLEN_W (16) | Retired instructions per quantum |
| loss_budget | input | TGT_W (8) | Allowed slowdown in units of 1/256 |
| coef_wr | input | 1 | Weight write enable |
| coef_set | input | 1 | Weight set: 0 wide-to-narrow, 1 narrow-to-wide |
| coef_sel | input | 3 | Weight index 0..6 |
| coef_data | input | COEF_W (16) | Signed weight value |
| use_little | output | 1 | 1 selects the narrow in-order engine |
| switch_req | output | 1 | One-cycle pulse on a change of selection |

## Verification
The assertions check on every cycle that the selection and the threshold move only at quantum ends, that a request pulse comes only with a change of selection and never twice in a row, and that reset release leaves the wide engine selected with a zero threshold. The arithmetic is left to the bench's scenarios: which weight set applies, saturation of products, sums and counters, the sign of the penalty, the feedback on the threshold, and dropped strobes at the boundary. The bench recomputes those against a reference model under random strobes, weights and targets, plus directed runs that saturate a product and an event counter.

// File: rtl/core_switch_ctrl.sv
module core_switch_ctrl #(
  parameter int CNT_W   = 16,
  parameter int COEF_W  = 16,
  parameter int ACC_W   = 24,
  parameter int QLEN_W  = 16,
  parameter int TGT_W   = 8,
  parameter int GAIN_SH = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     retire,
  input  logic                     ev_l2_miss,
  input  logic                     ev_l2_hit,
  input  logic                     ev_br_mispredict,
  input  logic                     ev_ilp,
  input  logic                     ev_mlp,
  input  logic                     cycle_tick,
  input  logic [QLEN_W-1:0]        quantum_len,
  input  logic [TGT_W-1:0]         loss_budget,
  input  logic                     coef_wr,
  input  logic                     coef_set,
  input  logic [2:0]               coef_sel,
  input  logic signed [COEF_W-1:0] coef_data,
  output logic                     use_little,
  output logic                     switch_req
);
  localparam int NEV   = 6;
  localparam int NCOEF = NEV + 1;
  localparam int WIDE  = ACC_W + COEF_W + CNT_W + TGT_W + 2;
  localparam logic signed [WIDE-1:0] SMAX = {{(WIDE-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [WIDE-1:0] SMIN = {{(WIDE-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [WIDE-1:0] v);
    if (v > SMAX) return SMAX[ACC_W-1:0];
    else if (v < SMIN) return SMIN[ACC_W-1:0];
    else return v[ACC_W-1:0];
  endfunction

  logic [CNT_W-1:0]         ev_cnt [NEV];
  logic [QLEN_W-1:0]        inst_cnt;
  logic signed [COEF_W-1:0] coef_q [2][NCOEF];
  logic signed [ACC_W-1:0]  thr_q, err_q;
  logic                     little_q, sw_q;

  wire [NEV-1:0]    ev      = {cycle_tick, ev_mlp, ev_ilp, ev_br_mispredict, ev_l2_hit, ev_l2_miss};
  wire [QLEN_W-1:0] qlen_e  = (quantum_len == '0) ? QLEN_W'(1) : quantum_len;
  wire              qend    = inst_cnt >= qlen_e;

  logic signed [ACC_W-1:0] est, pen, budget, loss, err_n, thr_n;
  logic                    go_little;

  always_comb begin
    logic signed [WIDE-1:0] prod, cyc_w, big_w;
    est = sat(WIDE'(coef_q[little_q][0]));
    for (int i = 0; i < NEV; i++) begin
      prod = WIDE'(coef_q[little_q][i+1]) * WIDE'($signed({1'b0, ev_cnt[i]}));
      est  = sat(WIDE'(est) + WIDE'(sat(prod)));
    end
    cyc_w = WIDE'($signed({1'b0, ev_cnt[NEV-1]}));
    pen   = little_q ? sat(cyc_w - WIDE'(est)) : sat(WIDE'(est) - cyc_w);
    big_w = little_q ? WIDE'(est) : cyc_w;
    if (big_w < 0) big_w = '0;
    budget    = sat((big_w * WIDE'($signed({1'b0, loss_budget}))) >>> TGT_W);
    loss      = little_q ? pen : '0;
    err_n     = sat(WIDE'(err_q) + WIDE'(budget) - WIDE'(loss));
    thr_n     = err_n >>> GAIN_SH;
    go_little = pen < thr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inst_cnt <= '0;
      little_q <= 1'b0;
      sw_q     <= 1'b0;
      thr_q    <= '0;
      err_q    <= '0;
      for (int i = 0; i < NEV; i++) ev_cnt[i] <= '0;
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < NCOEF; k++) coef_q[s][k] <= '0;
    end else begin
      sw_q <= 1'b0;
      if (qend) begin
        inst_cnt <= '0;
        for (int i = 0; i < NEV; i++) ev_cnt[i] <= '0;
        little_q <= go_little;
        sw_q     <= go_little != little_q;
        err_q    <= err_n;
        thr_q    <= thr_n;
      end else begin
        if (retire && inst_cnt != '1) inst_cnt <= inst_cnt + 1'b1;
        for (int i = 0; i < NEV; i++)
          if (ev[i] && ev_cnt[i] != '1) ev_cnt[i] <= ev_cnt[i] + 1'b1;
      end
      if (coef_wr && coef_sel <= 3'(NCOEF - 1)) coef_q[coef_set][coef_sel] <= coef_data;
    end
  end

  assign use_little = little_q;
  assign switch_req = sw_q;

  assert_reset_big_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!use_little && !switch_req && thr_q == '0));
  assert_select_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(qend) |-> $stable(use_little));
  assert_thr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(qend) |-> $stable(thr_q));
  assert_pulse_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |-> (use_little != $past(use_little)));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    switch_req |=> !switch_req);
  assert_counters_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(qend) |-> (inst_cnt == '0 && ev_cnt[NEV-1] == '0));
endmodule

// File: tb/test_core_switch_ctrl.sv
module test_core_switch_ctrl;
  localparam int ACC_W = 24;
  localparam int GAIN_SH = 2;
  localparam longint AMAX = (64'sd1 <<< (ACC_W-1)) - 1;
  localparam longint AMIN = -(64'sd1 <<< (ACC_W-1));

  logic clk = 0, rst_n = 0;
  logic retire = 0, ev_l2_miss = 0, ev_l2_hit = 0, ev_br_mispredict = 0, ev_ilp = 0, ev_mlp = 0, cycle_tick = 0;
  logic [15:0] quantum_len = 16'd4;
  logic [7:0]  loss_budget = 8'd13;
  logic coef_wr = 0, coef_set = 0;
  logic [2:0] coef_sel = 0;
  logic signed [15:0] coef_data = 0;
  logic use_little, switch_req;

  core_switch_ctrl i_core_switch_ctrl (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  longint m_cnt [6];
  longint m_inst, m_thr, m_err;
  longint m_coef [2][7];
  bit m_little, m_sw;

  function automatic longint sat(longint v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  task automatic model_step();
    longint ql, est, cyc, pen, bigc, budget, loss, errn;
    bit go;
    bit [5:0] ev;
    ev = {cycle_tick, ev_mlp, ev_ilp, ev_br_mispredict, ev_l2_hit, ev_l2_miss};
    ql = (quantum_len == 0) ? 1 : quantum_len;
    m_sw = 0;
    if (m_inst >= ql) begin
      est = sat(m_coef[m_little][0]);
      for (int i = 0; i < 6; i++) est = sat(est + sat(m_coef[m_little][i+1] * m_cnt[i]));
      cyc  = m_cnt[5];
      pen  = m_little ? sat(cyc - est) : sat(est - cyc);
      bigc = m_little ? est : cyc;
      if (bigc < 0) bigc = 0;
      budget = sat((bigc * loss_budget) >>> 8);
      loss = m_little ? pen : 0;
      errn = sat(m_err + budget - loss);
      go = pen < m_thr;
      m_sw = go != m_little;
      m_little = go;
      m_err = errn;
      m_thr = errn >>> GAIN_SH;
      m_inst = 0;
      for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    end else begin
      if (retire && m_inst < 65535) m_inst++;
      for (int i = 0; i < 6; i++) if (ev[i] && m_cnt[i] < 65535) m_cnt[i]++;
    end
    if (coef_wr && coef_sel <= 6) m_coef[coef_set][coef_sel] = coef_data;
  endtask

  task automatic check_out();
    checks++;
    if (use_little !== m_little) begin
      errors++;
      $display("FAIL %s use_little actual=%0d expected=%0d", cur_tag, use_little, m_little);
    end
    checks++;
    if (switch_req !== m_sw) begin
      errors++;
      $display("FAIL R7 switch_req actual=%0d expected=%0d", switch_req, m_sw);
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    check_out();
    coef_wr = 0;
  endtask

  task automatic rand_inputs(int rp);
    retire = ($urandom % 100) < rp;
    ev_l2_miss = $urandom % 2; ev_l2_hit = $urandom % 2; ev_br_mispredict = $urandom % 2;
    ev_ilp = $urandom % 2; ev_mlp = $urandom % 2; cycle_tick = ($urandom % 4) != 0;
  endtask

  task automatic write_coef(bit s, int k, int v);
    coef_wr = 1; coef_set = s; coef_sel = 3'(k); coef_data = 16'(v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_inst = 0; m_thr = 0; m_err = 0; m_little = 0; m_sw = 0;
    for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    for (int s = 0; s < 2; s++) for (int k = 0; k < 7; k++) m_coef[s][k] = 0;
    repeat (3) @(negedge clk);
    check_out();
    rst_n = 1;
    @(negedge clk);
    // R1: reset selection; first quantum with zero weights and zero threshold
    check_out();

    // R9: index 7 write ignored, zero weights give negative penalty -> narrow
    cur_tag = "R9";
    write_coef(0, 7, 30000);
    retire = 1; cycle_tick = 1;
    for (int c = 0; c < 12; c++) tick();

    // R2: quantum boundaries with zero length and strobes at boundary
    cur_tag = "R2";
    quantum_len = 0;
    for (int c = 0; c < 40; c++) begin rand_inputs(80); tick(); end
    quantum_len = 5;

    // R4: random weights in both sets
    cur_tag = "R4";
    for (int c = 0; c < 3000; c++) begin
      rand_inputs(70);
      if ($urandom % 8 == 0) write_coef($urandom % 2, $urandom % 8, int'($urandom % 64) - 32);
      if ($urandom % 200 == 0) quantum_len = 16'(3 + $urandom % 10);
      tick();
    end

    // R6: decisions across varied targets
    cur_tag = "R6";
    for (int c = 0; c < 4000; c++) begin
      rand_inputs(60);
      if ($urandom % 300 == 0) loss_budget = 8'($urandom);
      if ($urandom % 20 == 0) write_coef($urandom % 2, $urandom % 7, int'($urandom % 512) - 256);
      tick();
    end

    // R8: large target drives threshold feedback
    cur_tag = "R8";
    loss_budget = 8'd255;
    write_coef(0, 6, 2); tick();
    write_coef(1, 6, 1); tick();
    for (int c = 0; c < 2000; c++) begin rand_inputs(50); tick(); end

    // R10: long quanta, selection must hold between boundaries
    cur_tag = "R10";
    quantum_len = 60;
    for (int c = 0; c < 2000; c++) begin rand_inputs(40); tick(); end

    // R5: product of saturating weight and cycle count overflows the accumulator
    cur_tag = "R5";
    quantum_len = 2;
    retire = 0; {ev_l2_miss, ev_l2_hit, ev_br_mispredict, ev_ilp, ev_mlp} = '0; cycle_tick = 1;
    write_coef(0, 6, 32767); tick();
    write_coef(1, 6, -32768); tick();
    write_coef(0, 0, -32768); tick();
    for (int c = 0; c < 600; c++) tick();
    retire = 1;
    for (int c = 0; c < 8; c++) tick();

    // R3: cycle counter saturates at all-ones
    cur_tag = "R3";
    retire = 0;
    write_coef(0, 6, 1); tick();
    write_coef(1, 6, 1); tick();
    write_coef(0, 0, 0); tick();
    write_coef(1, 0, -70000 / 2); tick();
    for (int c = 0; c < 66000; c++) tick();
    retire = 1;
    for (int c = 0; c < 8; c++) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule